// File: doc/BRIEF.md
# Speculative Store Queue with Load Forwarding

This block holds stores between the store-issue logic and memory in an out-of-order core. A store enters the queue as soon as it executes, but it stays speculative until the in-order retire logic confirms it. Only confirmed stores are written to memory. A flush throws away every store that has not yet been confirmed, and leaves the confirmed ones in place to finish writing.

The queue is a circular array managed by three pointers. The write pointer marks the next free slot. The confirm pointer marks the oldest speculative entry. The drain pointer marks the oldest confirmed entry that memory has not yet accepted. A drain state machine has two states, `DR_IDLE` and `DR_SEND`:
- `DR_IDLE` moves to `DR_SEND` when at least one confirmed entry is waiting.
- `DR_SEND` holds a request with byte strobes until memory acknowledges it.
- On that acknowledge, `DR_SEND` stays in `DR_SEND` if another confirmed entry follows. Otherwise it returns to `DR_IDLE`.

A load-lookup port compares a load against every occupied entry in the same cycle. It either forwards the value of the newest exact match, or tells the load to wait when a store to the same word has a different size.

Top module: `spec_store_queue`

## Requirements
- R1: After reset, `full_o`, `mem_req_o`, `fwd_hit_o` and `fwd_stall_o` are low, and the queue holds no entries.
- R2: A store is accepted when `st_valid_i` is high, it is aligned, `full_o` is low and `flush_i` is low. `full_o` is high exactly when DEPTH entries are held. A store offered while full is dropped and leaves no trace at any port.
- R3: Size codes are 00 byte, 01 half-word, 10 word and 11 illegal. `st_misalign_o` is high in the same cycle as `st_valid_i` in three cases: a half-word with address bit 0 set, a word with address bits [1:0] non-zero, or size code 11. Such a store is not inserted.
- R4: Each `commit_i` pulse confirms exactly one entry, the oldest speculative one. A pulse while no speculative entry exists is ignored and does not confirm a later store.
- R5: Only confirmed entries are requested from memory, in insertion order. `mem_req_o` stays high until `mem_ack_i`, and the drain pointer advances on the acknowledge.
- R6: `mem_addr_o` is the store address with bits [1:0] cleared. `mem_strb_o` is 0001, 0011 or 1111 for byte, half-word or word, shifted left by address bits [1:0]. `mem_wdata_o` is the store value shifted left by 8 times address bits [1:0].
- R7: A flush discards every speculative entry: those entries are never written and never matched. Confirmed entries, including one being requested, stay and are written.
- R8: A lookup with `ld_valid_i` hits when an entry has exactly the same address and size. `fwd_data_o` is then the newest such entry's value, zero-extended from its size.
- R9: When any held entry has the same address bits [31:2] as the load but a different size, `fwd_stall_o` is high and `fwd_hit_o` is low.
- R10: A lookup that matches no entry's word, or matches only same-size entries at other byte addresses, gives neither hit nor stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid_i | input | 1 | Store offered for insertion |
| st_addr_i | input | ADDR_W | Store byte address |
| st_data_i | input | 32 | Store value, low-aligned |
| st_size_i | input | 2 | Store size code |
| st_misalign_o | output | 1 | Offered store is misaligned or has an illegal size |
| full_o | output | 1 | Queue holds DEPTH entries |
| commit_i | input | 1 | Retire logic confirms one store |
| flush_i | input | 1 | Discard all speculative stores |
| mem_req_o | output | 1 | Write request to memory |
| mem_addr_o | output | ADDR_W | Word-aligned write address |
| mem_strb_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Lane-placed write data |
| mem_ack_i | input | 1 | Memory accepted the request |
| ld_valid_i | input | 1 | Load lookup valid |
| ld_addr_i | input | ADDR_W | Load byte address |
| ld_size_i | input | 2 | Load size code |
| fwd_hit_o | output | 1 | Forwarded value available |
| fwd_stall_o | output | 1 | Load must wait |
| fwd_data_o | output | 32 | Forwarded value |

## Verification
The bench builds the queue with DEPTH=4 and ADDR_W=32. The small depth lets four stores fill the queue, so the full condition and the dropped fifth store can be reached directly. It also makes the pointers wrap several times during a run of ten stores. The bench holds memory acknowledges back at chosen moments. This keeps a confirmed request pending across a flush, and keeps speculative entries parked while forwarding, stalling and misses are probed against a known set of entries.

// File: rtl/stq_pkg.sv
package stq_pkg;

    localparam int DATA_W     = 32;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int OFF_W      = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } size_e;

    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_SEND = 1'b1
    } drain_state_e;

    function automatic logic size_misaligned(input logic [1:0] sz, input logic [OFF_W-1:0] off);
        logic bad;
        case (size_e'(sz))
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = off[0];
            SZ_WORD: bad = (off != '0);
            default: bad = 1'b1;
        endcase
        return bad;
    endfunction

    function automatic logic [WORD_BYTES-1:0] size_strobe(input logic [1:0] sz);
        logic [WORD_BYTES-1:0] s;
        case (size_e'(sz))
            SZ_BYTE: s = WORD_BYTES'(4'b0001);
            SZ_HALF: s = WORD_BYTES'(4'b0011);
            default: s = '1;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz, input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] m;
        case (size_e'(sz))
            SZ_BYTE: m = {{(DATA_W-8){1'b0}}, d[7:0]};
            SZ_HALF: m = {{(DATA_W-16){1'b0}}, d[15:0]};
            default: m = d;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/stq_ptr_ctrl.sv
module stq_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en_i,
    input  logic             commit_i,
    input  logic             flush_i,
    input  logic             pull_en_i,
    output logic [PTR_W-1:0] push_ptr_o,
    output logic [PTR_W-1:0] val_ptr_o,
    output logic [PTR_W-1:0] pull_ptr_o,
    output logic             full_o,
    output logic             pending_o,
    output logic             more_o
);

    logic [PTR_W-1:0] push_q, val_q, pull_q;
    logic [PTR_W-1:0] push_d, val_d, pull_d;
    logic [PTR_W-1:0] confirmed_cnt;
    logic             has_spec;

    assign has_spec      = (push_q != val_q);
    assign confirmed_cnt = val_q - pull_q;

    always_comb begin
        val_d  = val_q + PTR_W'(commit_i && has_spec);
        pull_d = pull_q + PTR_W'(pull_en_i);
        if (flush_i) begin
            push_d = val_d;
        end else begin
            push_d = push_q + PTR_W'(push_en_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_q <= '0;
            val_q  <= '0;
            pull_q <= '0;
        end else begin
            push_q <= push_d;
            val_q  <= val_d;
            pull_q <= pull_d;
        end
    end

    assign push_ptr_o = push_q;
    assign val_ptr_o  = val_q;
    assign pull_ptr_o = pull_q;
    assign full_o     = (push_q[IDX_W] != pull_q[IDX_W]) &&
                        (push_q[IDX_W-1:0] == pull_q[IDX_W-1:0]);
    assign pending_o  = (confirmed_cnt != '0);
    assign more_o     = (confirmed_cnt > PTR_W'(1));

    assert_no_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_q - pull_q) <= PTR_W'(DEPTH));

    assert_confirm_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (val_q - pull_q) <= (push_q - pull_q));

    assert_flush_rewinds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (push_q == val_q));

    assert_flush_keeps_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && !pull_en_i) |=> $stable(pull_q));

endmodule

// File: rtl/stq_drain_fsm.sv
module stq_drain_fsm
    import stq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic more_i,
    input  logic mem_ack_i,
    output logic mem_req_o,
    output logic pull_en_o
);

    drain_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE: if (pending_i) state_d = DR_SEND;
            DR_SEND: if (mem_ack_i && !more_i) state_d = DR_IDLE;
            default: state_d = DR_IDLE;
        endcase
    end

    always_comb begin
        mem_req_o = 1'b0;
        pull_en_o = 1'b0;
        unique case (state_q)
            DR_IDLE: ;
            DR_SEND: begin
                mem_req_o = 1'b1;
                pull_en_o = mem_ack_i;
            end
            default: ;
        endcase
    end

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> mem_req_o);

endmodule

// File: rtl/stq_fwd_match.sv
module stq_fwd_match
    import stq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr_i,
    input  logic [DEPTH-1:0][DATA_W-1:0] ent_data_i,
    input  logic [DEPTH-1:0][1:0]        ent_size_i,
    input  logic [PTR_W-1:0]             pull_ptr_i,
    input  logic [PTR_W-1:0]             push_ptr_i,
    input  logic                         ld_valid_i,
    input  logic [ADDR_W-1:0]            ld_addr_i,
    input  logic [1:0]                   ld_size_i,
    output logic                         hit_o,
    output logic                         stall_o,
    output logic [DATA_W-1:0]            data_o
);

    logic [PTR_W-1:0]  occ;
    logic              exact_any;
    logic              clash_any;
    logic [DATA_W-1:0] newest_data;
    logic [IDX_W-1:0]  slot;
    logic              same_word;

    assign occ = push_ptr_i - pull_ptr_i;

    always_comb begin
        exact_any   = 1'b0;
        clash_any   = 1'b0;
        newest_data = '0;
        slot        = '0;
        same_word   = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            slot      = pull_ptr_i[IDX_W-1:0] + IDX_W'(i);
            same_word = (ent_addr_i[slot][ADDR_W-1:OFF_W] == ld_addr_i[ADDR_W-1:OFF_W]);
            if ((PTR_W'(i) < occ) && same_word) begin
                if (ent_size_i[slot] != ld_size_i) begin
                    clash_any = 1'b1;
                end else if (ent_addr_i[slot][OFF_W-1:0] == ld_addr_i[OFF_W-1:0]) begin
                    exact_any   = 1'b1;
                    newest_data = ent_data_i[slot];
                end
            end
        end
    end

    assign stall_o = ld_valid_i && clash_any;
    assign hit_o   = ld_valid_i && exact_any && !clash_any;
    assign data_o  = hit_o ? newest_data : '0;

endmodule

// File: rtl/spec_store_queue.sv
module spec_store_queue
    import stq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [31:0]       st_data_i,
    input  logic [1:0]        st_size_i,
    output logic              st_misalign_o,
    output logic              full_o,
    input  logic              commit_i,
    input  logic              flush_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [3:0]        mem_strb_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic              ld_valid_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [1:0]        ld_size_i,
    output logic              fwd_hit_o,
    output logic              fwd_stall_o,
    output logic [31:0]       fwd_data_o
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic [DEPTH-1:0][ADDR_W-1:0] ent_addr_q;
    logic [DEPTH-1:0][DATA_W-1:0] ent_data_q;
    logic [DEPTH-1:0][1:0]        ent_size_q;

    logic [PTR_W-1:0] push_ptr, val_ptr, pull_ptr;
    logic             push_en, pull_en, pending, more;
    logic [IDX_W-1:0] push_idx, pull_idx;
    logic [OFF_W-1:0] head_off;

    assign st_misalign_o = st_valid_i && size_misaligned(st_size_i, st_addr_i[OFF_W-1:0]);
    assign push_en       = st_valid_i && !st_misalign_o && !full_o && !flush_i;
    assign push_idx      = push_ptr[IDX_W-1:0];
    assign pull_idx      = pull_ptr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (push_en) begin
            ent_addr_q[push_idx] <= st_addr_i;
            ent_data_q[push_idx] <= size_mask(st_size_i, st_data_i);
            ent_size_q[push_idx] <= st_size_i;
        end
    end

    stq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_en_i  (push_en),
        .commit_i   (commit_i),
        .flush_i    (flush_i),
        .pull_en_i  (pull_en),
        .push_ptr_o (push_ptr),
        .val_ptr_o  (val_ptr),
        .pull_ptr_o (pull_ptr),
        .full_o     (full_o),
        .pending_o  (pending),
        .more_o     (more)
    );

    stq_drain_fsm u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .more_i    (more),
        .mem_ack_i (mem_ack_i),
        .mem_req_o (mem_req_o),
        .pull_en_o (pull_en)
    );

    assign head_off = ent_addr_q[pull_idx][OFF_W-1:0];

    always_comb begin
        mem_addr_o  = '0;
        mem_strb_o  = '0;
        mem_wdata_o = '0;
        if (mem_req_o) begin
            mem_addr_o  = {ent_addr_q[pull_idx][ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            mem_strb_o  = size_strobe(ent_size_q[pull_idx]) << head_off;
            mem_wdata_o = ent_data_q[pull_idx] << {head_off, 3'b000};
        end
    end

    stq_fwd_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fwd (
        .ent_addr_i (ent_addr_q),
        .ent_data_i (ent_data_q),
        .ent_size_i (ent_size_q),
        .pull_ptr_i (pull_ptr),
        .push_ptr_i (push_ptr),
        .ld_valid_i (ld_valid_i),
        .ld_addr_i  (ld_addr_i),
        .ld_size_i  (ld_size_i),
        .hit_o      (fwd_hit_o),
        .stall_o    (fwd_stall_o),
        .data_o     (fwd_data_o)
    );

    assert_drain_confirmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (val_ptr != pull_ptr));

    assert_req_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> ($stable(mem_addr_o) && $stable(mem_strb_o) && $stable(mem_wdata_o)));

    assert_misalign_nopush_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_misalign_o && !flush_i) |=> $stable(push_ptr));

    assert_hit_stall_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_hit_o && fwd_stall_o));

    assert_full_no_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !pull_en) |=> full_o || $past(flush_i));

endmodule

// File: tb/test_spec_store_queue.sv
module test_spec_store_queue;

    localparam int DEPTH = 4;
    localparam int AW    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid_i = 1'b0;
    logic [AW-1:0] st_addr_i = '0;
    logic [31:0]   st_data_i = '0;
    logic [1:0]    st_size_i = '0;
    logic          st_misalign_o, full_o;
    logic          commit_i = 1'b0, flush_i = 1'b0;
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic [3:0]    mem_strb_o;
    logic [31:0]   mem_wdata_o;
    logic          mem_ack_i = 1'b0;
    logic          ld_valid_i = 1'b0;
    logic [AW-1:0] ld_addr_i = '0;
    logic [1:0]    ld_size_i = '0;
    logic          fwd_hit_o, fwd_stall_o;
    logic [31:0]   fwd_data_o;

    always #5 clk = ~clk;

    spec_store_queue #(.DEPTH(DEPTH), .ADDR_W(AW)) i_spec_store_queue (
        .clk(clk), .rst_n(rst_n),
        .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_data_i(st_data_i),
        .st_size_i(st_size_i), .st_misalign_o(st_misalign_o), .full_o(full_o),
        .commit_i(commit_i), .flush_i(flush_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_strb_o(mem_strb_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .ld_valid_i(ld_valid_i), .ld_addr_i(ld_addr_i), .ld_size_i(ld_size_i),
        .fwd_hit_o(fwd_hit_o), .fwd_stall_o(fwd_stall_o), .fwd_data_o(fwd_data_o)
    );

    typedef struct {
        logic [31:0] a;
        logic [3:0]  s;
        logic [31:0] d;
    } wr_t;

    wr_t exp_q[$];
    wr_t spec_q[$];
    int  n_chk = 0;
    int  n_fail = 0;
    bit  mem_en = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic wr_t model_wr(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz);
        wr_t w;
        logic [31:0] v;
        logic [3:0]  base;
        v    = (sz == 2'b00) ? (d & 32'hFF) : (sz == 2'b01) ? (d & 32'hFFFF) : d;
        base = (sz == 2'b00) ? 4'b0001 : (sz == 2'b01) ? 4'b0011 : 4'b1111;
        w.a = {a[31:2], 2'b00};
        w.s = base << a[1:0];
        w.d = v << (8 * a[1:0]);
        return w;
    endfunction

    // Scoreboard monitor and memory responder
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack_i <= 1'b0;
        end else if (mem_ack_i) begin
            mem_ack_i <= 1'b0;
        end else if (mem_en && mem_req_o) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R5 R7: actual write %h expected none", mem_addr_o);
            end else begin
                wr_t w;
                w = exp_q.pop_front();
                chk("R5 R6 address", mem_addr_o, w.a);
                chk("R6 strobe", {28'd0, mem_strb_o}, {28'd0, w.s});
                chk("R6 data", mem_wdata_o, w.d);
            end
            mem_ack_i <= 1'b1;
        end
    end

    task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                         input bit legal, input bit accept);
        @(negedge clk);
        st_valid_i = 1'b1; st_addr_i = a; st_data_i = d; st_size_i = sz;
        #1;
        chk("R3 misalign flag", {31'd0, st_misalign_o}, {31'd0, !legal});
        @(posedge clk);
        #1;
        st_valid_i = 1'b0;
        if (accept) spec_q.push_back(model_wr(a, d, sz));
    endtask

    task automatic commit();
        @(negedge clk);
        commit_i = 1'b1;
        if (spec_q.size() > 0) exp_q.push_back(spec_q.pop_front());
        @(posedge clk);
        #1;
        commit_i = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        flush_i = 1'b1;
        spec_q.delete();
        @(posedge clk);
        #1;
        flush_i = 1'b0;
    endtask

    task automatic lookup(input string req, input logic [31:0] a, input logic [1:0] sz,
                          input bit hit, input bit stall, input logic [31:0] d);
        @(negedge clk);
        ld_valid_i = 1'b1; ld_addr_i = a; ld_size_i = sz;
        #1;
        chk(req, {30'd0, fwd_hit_o, fwd_stall_o}, {30'd0, hit, stall});
        chk(req, fwd_data_o, d);
        ld_valid_i = 1'b0;
    endtask

    task automatic wait_drained();
        while (exp_q.size() > 0) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        bit timeout;
        timeout = 1'b0;
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                #1;
                // R1 reset state
                chk("R1 full", {31'd0, full_o}, 32'd0);
                chk("R1 req", {31'd0, mem_req_o}, 32'd0);
                chk("R1 fwd", {30'd0, fwd_hit_o, fwd_stall_o}, 32'd0);

                // R2 fill with memory held off
                store(32'h100, 32'h11111111, 2'b10, 1, 1);
                store(32'h104, 32'h22222222, 2'b10, 1, 1);
                store(32'h100, 32'h33333333, 2'b10, 1, 1);
                store(32'h109, 32'h00ABCD5A, 2'b00, 1, 1);
                chk("R2 full after DEPTH stores", {31'd0, full_o}, 32'd1);
                store(32'h200, 32'h99, 2'b10, 1, 0);
                lookup("R2 store while full dropped", 32'h200, 2'b10, 0, 0, 0);

                lookup("R8 newest exact match", 32'h100, 2'b10, 1, 0, 32'h33333333);
                lookup("R8 byte zero-extended", 32'h109, 2'b00, 1, 0, 32'h5A);
                lookup("R9 word over byte", 32'h108, 2'b10, 0, 1, 0);
                lookup("R9 half over word", 32'h104, 2'b01, 0, 1, 0);
                lookup("R10 other byte same word", 32'h10A, 2'b00, 0, 0, 0);
                lookup("R10 no word match", 32'h300, 2'b10, 0, 0, 0);

                // R5 nothing confirmed means nothing drains
                mem_en = 1'b1;
                repeat (5) @(posedge clk);
                #1;
                chk("R5 no request before confirm", {31'd0, mem_req_o}, 32'd0);

                // R7 flush with a request pending
                mem_en = 1'b0;
                commit();
                commit();
                repeat (3) @(negedge clk);
                chk("R5 request pending", {31'd0, mem_req_o}, 32'd1);
                flush();
                lookup("R7 discarded entry unmatched", 32'h108, 2'b10, 0, 0, 0);
                lookup("R7 confirmed entry kept", 32'h100, 2'b10, 1, 0, 32'h11111111);
                chk("R7 not full", {31'd0, full_o}, 32'd0);
                mem_en = 1'b1;
                wait_drained();
                chk("R5 idle after drain", {31'd0, mem_req_o}, 32'd0);

                // R4 stray confirm is ignored
                commit();
                store(32'h400, 32'h44, 2'b10, 1, 1);
                repeat (6) @(posedge clk);
                #1;
                chk("R4 stray confirm ignored", {31'd0, mem_req_o}, 32'd0);
                commit();
                wait_drained();

                // R3 and R6 lanes
                store(32'h303, 32'h0000EEFF, 2'b00, 1, 1);
                store(32'h302, 32'h1234ABCD, 2'b01, 1, 1);
                store(32'h301, 32'h5555, 2'b01, 0, 0);
                store(32'h302, 32'h6666, 2'b10, 0, 0);
                store(32'h300, 32'h7777, 2'b11, 0, 0);
                lookup("R3 misaligned half not held", 32'h301, 2'b01, 0, 1, 0);
                commit();
                commit();
                wait_drained();

                // R5 pointer wrap, in-order drain
                for (int i = 0; i < 10; i++) begin
                    store(32'h500 + 32'(4 * i), 32'h01010101 * 32'(i + 1), 2'b10, 1, 1);
                    commit();
                    repeat (3) @(posedge clk);
                end
                wait_drained();

                // R7 in-flight confirmed store survives flush
                mem_en = 1'b0;
                store(32'h600, 32'hCAFE0001, 2'b10, 1, 1);
                commit();
                store(32'h604, 32'hCAFE0002, 2'b10, 1, 1);
                repeat (2) @(posedge clk);
                flush();
                mem_en = 1'b1;
                wait_drained();
                repeat (6) @(posedge clk);
                #1;
                chk("R7 speculative never written", {31'd0, mem_req_o}, 32'd0);
                chk("R5 all expected writes seen", 32'(exp_q.size()), 32'd0);
            end
            begin
                repeat (100000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule